// File: doc/BRIEF.md
# Destination Address Filter with Multicast Hash

This block decides, from the six destination-address bytes at the head of an incoming Ethernet frame, whether the receiver should keep the frame. The bytes arrive one per clock, in the order they come off the wire. The first byte is marked by a start flag. A receive-configuration byte, a station address and a 64-bit multicast mask are applied as static inputs. They select the outcome:

- promiscuous acceptance of every frame;
- broadcast acceptance;
- multicast acceptance through a hash table;
- exact unicast matching.

The multicast hash is a CRC-32 variant. It is folded over all eight bits of each byte within the same cycle, so the filter never stalls the byte stream. One cycle after the sixth byte, a valid strobe comes up together with the accept flag. Both are held until the next frame starts.

Top module: `dst_addr_filter`

## Requirements
- R1: When `rx_cfg` bit 4 is 1, the frame is accepted whatever its destination.
- R2: A destination of six 0xFF bytes is broadcast. Outside promiscuous mode, it is accepted exactly when `rx_cfg` bit 2 is 1, whatever the multicast settings.
- R3: A non-broadcast destination whose first byte has bit 0 set is multicast. Outside promiscuous mode, it is accepted only when `rx_cfg` bit 3 is 1 and its hash bit in `mcast_mask` is 1.
- R4: The hash starts as 0xFFFFFFFF and takes the bits of each byte least significant first, bytes in arrival order. For each bit, the feedback is hash bit 31 XOR the input bit, and the hash is shifted left by one. When the feedback is 1, the shifted value is XORed with 0x04C11DB6 and bit 0 is then forced to 1.
- R5: The hash index is bits 31..26 of the final hash. The mask is tested at bit 8*(index>>3)+(index&7) of `mcast_mask`, which equals bit `index`.
- R6: Any other destination is accepted only when all six bytes equal `station_addr`. The first byte received is compared with bits 7:0, and the sixth with bits 47:40.
- R7: `res_valid` is 0 while a frame's address bytes are still arriving. It is 1, with `accept` valid, in the cycle after the sixth byte is taken.
- R8: Once valid, `res_valid` and `accept` hold their values, and further bytes without the start flag have no effect, until a byte with `in_first` set arrives.
- R9: A byte with `in_first` set starts a new frame and drops `res_valid` to 0 in the next cycle.
- R10: After reset, `res_valid` and `accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe for `in_byte` |
| in_first | input | 1 | Marks the first destination byte of a frame |
| in_byte | input | 8 | Destination address byte |
| rx_cfg | input | 8 | Receive configuration: bit 2 broadcast, bit 3 multicast, bit 4 promiscuous |
| station_addr | input | 8*NBYTES | Own address, first-received byte in bits 7:0 |
| mcast_mask | input | 2**HASH_W | Multicast hash table |
| res_valid | output | 1 | Decision valid |
| accept | output | 1 | Frame accepted |

## Verification
The bench builds the filter with its default parameters: a six-byte address and a six-bit hash index into a 64-entry mask. With these values the real Ethernet hash can be checked. The bench computes a multicast group's index independently and then sets exactly that mask bit, or every other bit, to probe both sides of the table lookup. With the six-byte window, the bench can also send bytes past the end of the address and confirm that the held decision does not move. A mismatch only in the last unicast byte, and a broadcast destination that also looks like multicast, exercise the decision precedence.

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
  parameter int NBYTES = 6,
  parameter int HASH_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic [7:0]               in_byte,
  input  logic [7:0]               rx_cfg,
  input  logic [8*NBYTES-1:0]      station_addr,
  input  logic [(1<<HASH_W)-1:0]   mcast_mask,
  output logic                     res_valid,
  output logic                     accept
);
  localparam int CNT_W = $clog2(NBYTES + 1);
  localparam logic [31:0] POLY = 32'h04C11DB6;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int j = 0; j < 8; j++) begin
      fb = r[31] ^ b[j];
      r  = {r[30:0], 1'b0};
      if (fb) r = (r ^ POLY) | 32'd1;
    end
    return r;
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic [31:0]       crc;
  logic              bcast, mcast, umatch;

  logic              take, last, decide;
  logic [CNT_W-1:0]  pos;
  logic [31:0]       crc_nx;
  logic              bcast_nx, mcast_nx, umatch_nx;
  logic [HASH_W-1:0] hash_idx;

  assign pos       = in_first ? '0 : cnt;
  assign take      = in_valid && (in_first || (cnt != '0 && cnt < CNT_W'(NBYTES)));
  assign last      = take && (pos == CNT_W'(NBYTES - 1));
  assign crc_nx    = crc_byte(in_first ? 32'hFFFF_FFFF : crc, in_byte);
  assign bcast_nx  = (in_first | bcast) & (in_byte == 8'hFF);
  assign mcast_nx  = in_first ? in_byte[0] : mcast;
  assign umatch_nx = (in_first | umatch) & (in_byte == station_addr[8*pos +: 8]);
  assign hash_idx  = crc_nx[31 -: HASH_W];
  assign decide    = rx_cfg[4] | (bcast_nx ? rx_cfg[2] :
                                  mcast_nx ? (rx_cfg[3] & mcast_mask[hash_idx]) :
                                             umatch_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      crc       <= 32'hFFFF_FFFF;
      bcast     <= 1'b0;
      mcast     <= 1'b0;
      umatch    <= 1'b0;
      res_valid <= 1'b0;
      accept    <= 1'b0;
    end else if (take) begin
      cnt       <= pos + 1'b1;
      crc       <= crc_nx;
      bcast     <= bcast_nx;
      mcast     <= mcast_nx;
      umatch    <= umatch_nx;
      res_valid <= last;
      if (last)          accept <= decide;
      else if (in_first) accept <= 1'b0;
    end
  end

  a_r7_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> res_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(in_valid && in_first)) |=> (res_valid && $stable(accept)));

  a_r9_first_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && !last) |=> !res_valid);

  a_r1_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (last && rx_cfg[4]) |=> accept);

  a_r2_bcast_off: assert property (@(posedge clk) disable iff (!rst_n)
    (last && bcast_nx && !rx_cfg[4] && !rx_cfg[2]) |=> !accept);

  a_r10_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!res_valid && !accept));
endmodule

// File: tb/dst_addr_filter_tb_top.sv
module dst_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [7:0]  rx_cfg = 8'h00;
  logic [47:0] station_addr = 48'h0;
  logic [63:0] mcast_mask = 64'h0;
  logic        res_valid, accept;
  int          n_chk = 0, n_fail = 0;

  always #10ns clk = ~clk;

  dst_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_byte(in_byte), .rx_cfg(rx_cfg), .station_addr(station_addr),
    .mcast_mask(mcast_mask), .res_valid(res_valid), .accept(accept));

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic logic [5:0] hidx(input logic [47:0] da);
    logic [31:0] h = 32'hFFFF_FFFF;
    logic f;
    for (int i = 0; i < 48; i++) begin
      f = h[31] ^ da[i];
      h = h << 1;
      if (f) h = (h ^ 32'h04C11DB6) | 32'd1;
    end
    return h[31:26];
  endfunction

  task automatic send(input logic [47:0] da, input string req, input logic exp);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 5) check({req, " R7 not valid early"}, res_valid, 1'b0);
      in_valid = 1'b1; in_first = (i == 0); in_byte = da[8*i +: 8];
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    check({req, " R7 valid"}, res_valid, 1'b1);
    check(req, accept, exp);
  endtask

  task automatic t_reset;
    check("R10 valid", res_valid, 1'b0);
    check("R10 accept", accept, 1'b0);
  endtask

  task automatic t_unicast;
    rx_cfg = 8'h00;
    station_addr = mk(8'h52, 8'h54, 8'h00, 8'h12, 8'h34, 8'h56);
    send(station_addr, "R6 match", 1'b1);
    send(mk(8'h52, 8'h54, 8'h00, 8'h12, 8'h34, 8'h57), "R6 last byte differs", 1'b0);
    send(mk(8'h50, 8'h54, 8'h00, 8'h12, 8'h34, 8'h56), "R6 first byte differs", 1'b0);
  endtask

  task automatic t_broadcast;
    mcast_mask = '1;
    rx_cfg = 8'h08;
    send('1, "R2 bcast off despite mcast", 1'b0);
    rx_cfg = 8'h04;
    send('1, "R2 bcast on", 1'b1);
  endtask

  task automatic t_multicast;
    logic [47:0] g = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
    logic [5:0]  ix = hidx(g);
    rx_cfg = 8'h08;
    mcast_mask = 64'd1 << ix;
    send(g, "R4 R5 R3 hash hit", 1'b1);
    mcast_mask = ~(64'd1 << ix);
    send(g, "R5 R3 hash miss", 1'b0);
    mcast_mask = '1;
    rx_cfg = 8'h00;
    send(g, "R3 mcast disabled", 1'b0);
  endtask

  task automatic t_promisc;
    rx_cfg = 8'h10;
    mcast_mask = '0;
    send(mk(8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFE), "R1 promisc unicast", 1'b1);
    send(mk(8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), "R1 promisc mcast", 1'b1);
  endtask

  task automatic t_hold_restart;
    rx_cfg = 8'h00;
    send(station_addr, "R8 setup", 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = 1'b0; in_byte = 8'h99;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 valid held", res_valid, 1'b1);
    check("R8 accept held", accept, 1'b1);
    in_valid = 1'b1; in_first = 1'b1; in_byte = 8'h00;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    check("R9 restart clears valid", res_valid, 1'b0);
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_broadcast();
    t_multicast();
    t_promisc();
    t_hold_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule